// File: doc/BRIEF.md
# Masked Arithmetic Flag Generator

This block forms the condition-flag word that follows an add or subtract. It takes the previous flag word, a per-bit update mask, the two adder operands, the adder result, a subtract indicator and an operand-size select. Each flag bit enabled in the mask is recomputed at the selected operand width. Every other bit is copied from the previous word. Carry, parity, auxiliary carry, zero, sign and overflow are produced. Two further flags are produced with them: an uninverted "extended carry" and a duplicate "extended zero".

The contract with the ALU is that `result` equals `op_a + op_b + is_sub`, truncated to the operand width. For a subtract the ALU passes the subtrahend already inverted in `op_b` and raises `is_sub`. The block then inverts the carry and the auxiliary carry so that they read as borrows. The new word is held in an output register and appears one clock after its inputs. A parameter can remove that register and leave a purely combinational path.

Top module: `mflag_unit`

## Requirements
- R1: Every flag bit whose `upd_mask` bit is 0 equals the same bit of `old_flags`.
- R2: Every flag bit whose mask bit is 1 takes the freshly computed value, whether that value is 0 or 1. The bit positions are: carry 0, parity 2, extended carry 3, auxiliary carry 4, extended zero 5, zero 6, sign 7, overflow 11. All other masked positions compute as 0.
- R3: Carry (bit 0) is the carry out of the top bit of `op_a + op_b + is_sub` at the selected width, inverted when `is_sub` is 1.
- R4: Auxiliary carry (bit 4) is the carry out of bit 3 of that same sum, inverted when `is_sub` is 1.
- R5: Parity (bit 2) is 1 when `result[7:0]` holds an even number of ones, at every width.
- R6: Zero (bit 6) is 1 when the result bits below the selected width are all 0. Result bits at or above the width have no effect.
- R7: Sign (bit 7) is the result bit at position width-1.
- R8: Overflow (bit 11) is 1 when `op_a` and `op_b` have equal sign bits at the selected width and the result's sign bit differs from them.
- R9: Extended carry (bit 3) is the uninverted carry out of the top bit, identical to R3 for an add and its complement for a subtract.
- R10: Extended zero (bit 5) is 1 under exactly the same condition as zero.
- R11: `size_sel` encodes the width as follows: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits.
- R12: With the output register present (default), `flags_out` shows the word computed from the inputs before a rising clock edge, starting at that edge. A synchronous active-high `rst` clears `flags_out` to 0 at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset, clears the output |
| old_flags | input | 16 | Flag word before the operation |
| upd_mask | input | 16 | 1 marks a flag bit to recompute |
| op_a | input | 64 | First adder operand |
| op_b | input | 64 | Second adder operand, inverted by the ALU for a subtract |
| result | input | 64 | Adder result, op_a + op_b + is_sub |
| is_sub | input | 1 | 1 for a subtract: carry-in and borrow inversion |
| size_sel | input | 2 | Operand width select (R11) |
| flags_out | output | 16 | New flag word, registered |

## Verification
All flag results pass through one output register, so each one is due at the first rising edge after its inputs settle. The same holds for the clearing by reset. The bench changes inputs just after a falling edge and reads `flags_out` at the next falling edge, half a period after the capturing edge. This gives exactly one register stage between stimulus and sample for the table vectors, the directed cases and the random operands at all four widths.

// File: rtl/mflag_pkg.sv
package mflag_pkg;

    // Flag bit positions inside the flag word
    localparam int POS_CARRY  = 0;
    localparam int POS_PARITY = 2;
    localparam int POS_XCARRY = 3;
    localparam int POS_AUX    = 4;
    localparam int POS_XZERO  = 5;
    localparam int POS_ZERO   = 6;
    localparam int POS_SIGN   = 7;
    localparam int POS_OVFL   = 11;

    // Highest position used; the flag word must be wider than this
    localparam int POS_TOP    = POS_OVFL;

    // Operand width codes
    typedef enum logic [1:0] {
        SIZE_8  = 2'd0,
        SIZE_16 = 2'd1,
        SIZE_32 = 2'd2,
        SIZE_64 = 2'd3
    } size_e;

    // Freshly computed flag values, before masking
    typedef struct packed {
        logic carry;
        logic parity;
        logic xcarry;
        logic aux;
        logic xzero;
        logic zero;
        logic sign;
        logic ovfl;
    } flag_calc_t;

    // Even number of ones in a byte
    function automatic logic even_ones(input logic [7:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/mflag_width_view.sv
module mflag_width_view #(
    parameter int DATA_W    = 64,
    parameter int NUM_SIZES = 4,
    parameter int SEL_W     = 2
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] result,
    input  logic [SEL_W-1:0]  size_sel,
    output logic [DATA_W-1:0] a_trim,
    output logic [DATA_W-1:0] b_trim,
    output logic              a_top,
    output logic              b_top,
    output logic              r_top,
    output logic              r_zero
);

    logic [DATA_W-1:0]    lane_mask [NUM_SIZES];
    logic [NUM_SIZES-1:0] a_top_at;
    logic [NUM_SIZES-1:0] b_top_at;
    logic [NUM_SIZES-1:0] r_top_at;
    logic [NUM_SIZES-1:0] r_zero_at;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int W = 8 << g;
        if (W >= DATA_W) begin : g_full
            assign lane_mask[g] = '1;
        end else begin : g_part
            assign lane_mask[g] = {{(DATA_W-W){1'b0}}, {W{1'b1}}};
        end
        assign a_top_at[g]  = op_a[W-1];
        assign b_top_at[g]  = op_b[W-1];
        assign r_top_at[g]  = result[W-1];
        assign r_zero_at[g] = ~(|result[W-1:0]);
    end

    always_comb begin
        a_trim = op_a & lane_mask[size_sel];
        b_trim = op_b & lane_mask[size_sel];
        a_top  = a_top_at[size_sel];
        b_top  = b_top_at[size_sel];
        r_top  = r_top_at[size_sel];
        r_zero = r_zero_at[size_sel];
    end

endmodule

// File: rtl/mflag_arith.sv
module mflag_arith #(
    parameter int DATA_W    = 64,
    parameter int NUM_SIZES = 4,
    parameter int SEL_W     = 2
) (
    input  logic [DATA_W-1:0] a_trim,
    input  logic [DATA_W-1:0] b_trim,
    input  logic              a_top,
    input  logic              b_top,
    input  logic              r_top,
    input  logic              is_sub,
    input  logic [SEL_W-1:0]  size_sel,
    output logic              carry_raw,
    output logic              aux_raw,
    output logic              ovfl
);

    localparam int SUM_W = DATA_W + 1;

    logic [SUM_W-1:0]     sum_full;
    logic [4:0]           nib_sum;
    logic [NUM_SIZES-1:0] carry_at;

    // One shared adder on width-trimmed operands: bit W of the sum is
    // the carry out of bit W-1 at every selectable width.
    assign sum_full = {1'b0, a_trim} + {1'b0, b_trim} + {{DATA_W{1'b0}}, is_sub};

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_cout
        localparam int W = 8 << g;
        localparam logic [SUM_W-1:0] PICK = SUM_W'(1) << W;
        assign carry_at[g] = |(sum_full & PICK);
    end

    assign nib_sum = {1'b0, a_trim[3:0]} + {1'b0, b_trim[3:0]} + {4'd0, is_sub};

    always_comb begin
        carry_raw = carry_at[size_sel];
        aux_raw   = |(nib_sum & 5'b10000);
        // carry into the top bit is a ^ b ^ result at that bit;
        // overflow is carry-in differing from carry-out there
        ovfl      = a_top ^ b_top ^ r_top ^ carry_raw;
    end

endmodule

// File: rtl/mflag_result_flags.sv
module mflag_result_flags (
    input  logic [7:0] r_low,
    input  logic       r_top,
    input  logic       r_zero,
    output logic       parity,
    output logic       zero,
    output logic       sign
);
    import mflag_pkg::*;

    always_comb begin
        parity = even_ones(r_low);
        zero   = r_zero;
        sign   = r_top;
    end

endmodule

// File: rtl/mflag_merge.sv
module mflag_merge #(
    parameter int FLAG_W = 16
) (
    input  logic [FLAG_W-1:0]     old_flags,
    input  logic [FLAG_W-1:0]     upd_mask,
    input  mflag_pkg::flag_calc_t calc,
    output logic [FLAG_W-1:0]     flags_next
);
    import mflag_pkg::*;

    logic [FLAG_W-1:0] fresh;

    always_comb begin
        fresh             = '0;
        fresh[POS_CARRY]  = calc.carry;
        fresh[POS_PARITY] = calc.parity;
        fresh[POS_XCARRY] = calc.xcarry;
        fresh[POS_AUX]    = calc.aux;
        fresh[POS_XZERO]  = calc.xzero;
        fresh[POS_ZERO]   = calc.zero;
        fresh[POS_SIGN]   = calc.sign;
        fresh[POS_OVFL]   = calc.ovfl;
        flags_next        = (old_flags & ~upd_mask) | (fresh & upd_mask);
    end

endmodule

// File: rtl/mflag_unit.sv
module mflag_unit #(
    parameter int DATA_W  = 64,
    parameter int FLAG_W  = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] old_flags,
    input  logic [FLAG_W-1:0] upd_mask,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] result,
    input  logic              is_sub,
    input  logic [1:0]        size_sel,
    output logic [FLAG_W-1:0] flags_out
);
    import mflag_pkg::*;

    localparam int NUM_SIZES = $clog2(DATA_W / 8) + 1;
    localparam int SEL_W     = 2;

    logic [DATA_W-1:0] a_trim;
    logic [DATA_W-1:0] b_trim;
    logic              a_top;
    logic              b_top;
    logic              r_top;
    logic              r_zero;
    logic              carry_raw;
    logic              aux_raw;
    logic              ovfl;
    logic              parity;
    logic              zero;
    logic              sign;
    flag_calc_t        calc;
    logic [FLAG_W-1:0] flags_next;

    mflag_width_view #(
        .DATA_W    (DATA_W),
        .NUM_SIZES (NUM_SIZES),
        .SEL_W     (SEL_W)
    ) u_view (
        .op_a     (op_a),
        .op_b     (op_b),
        .result   (result),
        .size_sel (size_sel),
        .a_trim   (a_trim),
        .b_trim   (b_trim),
        .a_top    (a_top),
        .b_top    (b_top),
        .r_top    (r_top),
        .r_zero   (r_zero)
    );

    mflag_arith #(
        .DATA_W    (DATA_W),
        .NUM_SIZES (NUM_SIZES),
        .SEL_W     (SEL_W)
    ) u_arith (
        .a_trim    (a_trim),
        .b_trim    (b_trim),
        .a_top     (a_top),
        .b_top     (b_top),
        .r_top     (r_top),
        .is_sub    (is_sub),
        .size_sel  (size_sel),
        .carry_raw (carry_raw),
        .aux_raw   (aux_raw),
        .ovfl      (ovfl)
    );

    mflag_result_flags u_res (
        .r_low  (result[7:0]),
        .r_top  (r_top),
        .r_zero (r_zero),
        .parity (parity),
        .zero   (zero),
        .sign   (sign)
    );

    always_comb begin
        calc.carry  = carry_raw ^ is_sub;
        calc.parity = parity;
        calc.xcarry = carry_raw;
        calc.aux    = aux_raw ^ is_sub;
        calc.xzero  = zero;
        calc.zero   = zero;
        calc.sign   = sign;
        calc.ovfl   = ovfl;
    end

    mflag_merge #(
        .FLAG_W (FLAG_W)
    ) u_merge (
        .old_flags  (old_flags),
        .upd_mask   (upd_mask),
        .calc       (calc),
        .flags_next (flags_next)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) flags_out <= '0;
            else     flags_out <= flags_next;
        end
    end else begin : g_comb
        assign flags_out = flags_next;
    end

endmodule

// File: rtl/mflag_unit_checker.sv
module mflag_unit_checker #(
    parameter int FLAG_W  = 16,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [FLAG_W-1:0] old_flags,
    input logic [FLAG_W-1:0] upd_mask,
    input logic              is_sub,
    input logic [FLAG_W-1:0] flags_next,
    input logic [FLAG_W-1:0] flags_out
);
    import mflag_pkg::*;

    // R1: unmasked bits follow the old word
    assert_keep_unmasked_R1: assert property (@(posedge clk) disable iff (rst)
        (flags_next & ~upd_mask) == (old_flags & ~upd_mask));

    // R9: extended carry relates to carry through the subtract inversion
    assert_xcarry_link_R9: assert property (@(posedge clk) disable iff (rst)
        (upd_mask[POS_CARRY] && upd_mask[POS_XCARRY]) |->
        (flags_next[POS_CARRY] == (flags_next[POS_XCARRY] ^ is_sub)));

    // R10: extended zero matches zero
    assert_xzero_link_R10: assert property (@(posedge clk) disable iff (rst)
        (upd_mask[POS_ZERO] && upd_mask[POS_XZERO]) |->
        (flags_next[POS_ZERO] == flags_next[POS_XZERO]));

    // R7: a zero result never carries a set sign bit
    assert_zero_not_neg_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_mask[POS_ZERO] && upd_mask[POS_SIGN]) |->
        !(flags_next[POS_ZERO] && flags_next[POS_SIGN]));

    if (OUT_REG) begin : g_reg_chk
        // R12: one register stage between merge and output
        assert_out_delay_R12: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (flags_out == $past(flags_next)));

        // R12: reset clears the output at the edge
        assert_reset_clear_R12: assert property (@(posedge clk)
            rst |=> (flags_out == '0));
    end

endmodule

bind mflag_unit mflag_unit_checker #(
    .FLAG_W  (FLAG_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .old_flags  (old_flags),
    .upd_mask   (upd_mask),
    .is_sub     (is_sub),
    .flags_next (flags_next),
    .flags_out  (flags_out)
);

// File: tb/mflag_unit_bench.sv
`timescale 1ns/1ps
module mflag_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] old_flags = '0;
    logic [15:0] upd_mask = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [63:0] result = '0;
    logic        is_sub = 1'b0;
    logic [1:0]  size_sel = '0;
    logic [15:0] flags_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mflag_unit u_mflag_unit (
        .clk       (clk),
        .rst       (rst),
        .old_flags (old_flags),
        .upd_mask  (upd_mask),
        .op_a      (op_a),
        .op_b      (op_b),
        .result    (result),
        .is_sub    (is_sub),
        .size_sel  (size_sel),
        .flags_out (flags_out)
    );

    typedef struct packed {
        logic [1:0]  sz;
        logic        sub;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] d;
        logic [15:0] msk;
        logic [15:0] old;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 64'hFF, 64'h01, 64'h100, 16'h08FD, 16'h0000, 16'h007D},
        '{2'd0, 1'b0, 64'h7F, 64'h01, 64'h80, 16'h08FD, 16'h0000, 16'h0890},
        '{2'd0, 1'b1, 64'h05, 64'hFFFF_FFFF_FFFF_FFFC, 64'h02, 16'h08FD, 16'h0000, 16'h0008},
        '{2'd0, 1'b1, 64'h03, 64'hFFFF_FFFF_FFFF_FFFA, 64'hFFFF_FFFF_FFFF_FFFE, 16'h08FD, 16'h0000, 16'h0091},
        '{2'd1, 1'b0, 64'h1234_0000, 64'h0, 64'h1234_0000, 16'h08FD, 16'h0000, 16'h0064},
        '{2'd3, 1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 16'h0041, 16'hF000, 16'hF041},
        '{2'd2, 1'b0, 64'h1, 64'h1, 64'h2, 16'h08FD, 16'hFFFF, 16'hF702},
        '{2'd2, 1'b0, 64'h8000_0000, 64'h8000_0000, 64'h1_0000_0000, 16'h08FD, 16'h0000, 16'h086D}
    };

    string vnames [NV] = '{
        "R3 R4 R5 R6 R10 byte add wrapping to zero",
        "R7 R8 R5 byte signed overflow",
        "R3 R9 R4 byte subtract without borrow",
        "R3 R4 R9 R7 byte subtract with borrow",
        "R6 R11 halfword ignores upper result bits",
        "R2 R3 R11 doubleword partial mask",
        "R2 word masked bits cleared",
        "R8 R11 word overflow, upper result ignored"
    };

    function automatic logic [15:0] ref_flags(
        input logic [15:0] old, input logic [15:0] msk,
        input logic [63:0] a, input logic [63:0] b, input logic [63:0] d,
        input logic sub, input logic [1:0] sz);
        logic c, o, z, s;
        logic [7:0]  t8;
        logic [15:0] t16;
        logic [31:0] t32;
        logic [63:0] t64;
        logic [4:0]  nb;
        logic [15:0] w;
        case (sz)
            2'd0: begin
                {c, t8} = {1'b0, a[7:0]} + {1'b0, b[7:0]} + {8'd0, sub};
                o = (a[7] == b[7]) && (d[7] != a[7]);
                z = (d[7:0] == 8'd0);
                s = d[7];
            end
            2'd1: begin
                {c, t16} = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'd0, sub};
                o = (a[15] == b[15]) && (d[15] != a[15]);
                z = (d[15:0] == 16'd0);
                s = d[15];
            end
            2'd2: begin
                {c, t32} = {1'b0, a[31:0]} + {1'b0, b[31:0]} + {32'd0, sub};
                o = (a[31] == b[31]) && (d[31] != a[31]);
                z = (d[31:0] == 32'd0);
                s = d[31];
            end
            default: begin
                {c, t64} = {1'b0, a} + {1'b0, b} + {64'd0, sub};
                o = (a[63] == b[63]) && (d[63] != a[63]);
                z = (d == 64'd0);
                s = d[63];
            end
        endcase
        nb = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, sub};
        w = '0;
        w[0]  = c ^ sub;
        w[2]  = ~(^d[7:0]);
        w[3]  = c;
        w[4]  = nb[4] ^ sub;
        w[5]  = z;
        w[6]  = z;
        w[7]  = s;
        w[11] = o;
        return (old & ~msk) | (w & msk);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] sz, input logic sub,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] d,
                         input logic [15:0] msk, input logic [15:0] old);
        size_sel  = sz;
        is_sub    = sub;
        op_a      = a;
        op_b      = b;
        result    = d;
        upd_mask  = msk;
        old_flags = old;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        check("R12 output cleared in reset", flags_out, 16'h0000);
        rst = 1'b0;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].sz, VECS[i].sub, VECS[i].a, VECS[i].b, VECS[i].d,
                  VECS[i].msk, VECS[i].old);
            check(vnames[i], flags_out, VECS[i].exp);
        end

        // R1: nothing masked, flags-setting operands have no effect
        apply(2'd0, 1'b0, 64'hFF, 64'h01, 64'h100, 16'h0000, 16'hA5A5);
        check("R1 empty mask keeps old word", flags_out, 16'hA5A5);

        // R5: parity even / odd on the low byte
        apply(2'd2, 1'b0, 64'h0003_0003, 64'h0, 64'h0003_0003, 16'h0004, 16'h0000);
        check("R5 even ones sets parity", flags_out, 16'h0004);
        apply(2'd2, 1'b0, 64'h0007, 64'h0, 64'h0007, 16'h0004, 16'h0004);
        check("R5 odd ones clears parity", flags_out, 16'h0000);

        // R6 / R11: same operands, zero only at the narrow width
        apply(2'd0, 1'b0, 64'h0100, 64'h0, 64'h0100, 16'h0040, 16'h0000);
        check("R6 byte zero with upper bits set", flags_out, 16'h0040);
        apply(2'd1, 1'b0, 64'h0100, 64'h0, 64'h0100, 16'h0040, 16'h0000);
        check("R6 R11 halfword not zero", flags_out, 16'h0000);

        // R12: synchronous reset in the middle of traffic
        size_sel = 2'd0; is_sub = 1'b0; op_a = 64'hFF; op_b = 64'h01;
        result = 64'h100; upd_mask = 16'h08FD; old_flags = 16'hFFFF;
        rst = 1'b1;
        @(negedge clk);
        check("R12 reset clears output mid-run", flags_out, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check("R12 output resumes after reset", flags_out,
              ref_flags(16'hFFFF, 16'h08FD, 64'hFF, 64'h01, 64'h100, 1'b0, 2'd0));

        // Random operands at all widths against the bench model
        for (int k = 0; k < 240; k++) begin
            logic [63:0] ra, rb, bi, rd;
            logic [15:0] rm, ro;
            logic        rs;
            logic [1:0]  rz;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            rs = $urandom_range(0, 1) == 1;
            rz = 2'(k % 4);
            rm = (k % 3 == 0) ? 16'h08FD : 16'($urandom);
            ro = 16'($urandom);
            bi = rs ? ~rb : rb;
            if (k % 8 == 5) ra = 64'd0 - bi - {63'd0, rs};
            rd = ra + bi + {63'd0, rs};
            apply(rz, rs, ra, bi, rd, rm, ro);
            check("R2 R3 R4 R8 R9 R11 random operands", flags_out,
                  ref_flags(ro, rm, ra, bi, rd, rs, rz));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule